// File: doc/BRIEF.md
# Double-Precision to 64-bit Integer Converter

This block turns a 64-bit binary floating-point operand into a 64-bit integer, either two's-complement signed or unsigned, under one of four rounding modes. A value that does not fit the chosen destination is clamped to the nearest end of the range. The block also produces the status outputs that go with the conversion: sticky-flag updates, the exception-summary update, fraction status bits, an overflow indication and a destination write enable.

The conversion is a combinational path. It classifies the operand, rounds it in fixed point, then checks the range and saturates. One register stage at the output captures all results. Results appear on the outputs one clock after the inputs are presented. An invalid-operation trap enable decides whether an invalid conversion suppresses the destination write. An overflow-report enable decides whether overflow reaches the summary-overflow output.

Top module: `fcvt_f2i`

## Requirements
- R1: All outputs are registered and show the result of the inputs sampled at the previous rising clock edge. While rst_n is low, every output is 0.
- R2: rmode_i selects the rounding of a non-integral value. 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward +infinity and 11 rounds toward -infinity. An in-range value yields the rounded integer on res_o, in two's complement when is_signed_i is 1.
- R3: ovf_o is 1 for a NaN or infinite operand, or when the rounded value lies outside the destination range. In that case inv_cvt_o is 1 and inexact_o is 0.
- R4: Out-of-range values saturate. Signed positive gives 0x7FFF_FFFF_FFFF_FFFF and signed negative gives 0x8000_0000_0000_0000. Unsigned positive gives all ones and unsigned negative gives 0. A NaN gives 0x8000_0000_0000_0000 when signed and 0 when unsigned.
- R5: When there is no overflow, inexact_o is 1 exactly when the operand is not an integer. A negative fraction that rounds to 0 in unsigned mode is therefore inexact without overflow.
- R6: sig_nan_o is 1 only for a NaN whose fraction bit 51 (the quiet bit) is 0.
- R7: exc_sum_o is the OR of sig_nan_o, inv_cvt_o and inexact_o.
- R8: Let the trap condition be inv_en_i AND (signaling-NaN OR invalid-conversion). When the trap condition is 1, wr_en_o is 0 and frac_rnd_o and frac_inx_o are 0. Otherwise wr_en_o is 1, frac_rnd_o follows the round-up indication and frac_inx_o equals inexact_o.
- R9: sum_ovf_o equals ovf_o AND ovf_en_i, with ovf_en_i taken from the same input cycle.
- R10: The round-up indication is 1 exactly when the rounded magnitude is larger than the truncated magnitude. This includes operands below 0.5 in magnitude that round away from zero to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Floating-point operand |
| is_signed_i | input | 1 | 1: signed destination, 0: unsigned |
| rmode_i | input | 2 | Rounding mode select |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| ovf_en_i | input | 1 | Overflow-report enable |
| res_o | output | 64 | Integer result |
| wr_en_o | output | 1 | Destination write enable |
| sig_nan_o | output | 1 | Signaling-NaN flag update |
| inv_cvt_o | output | 1 | Invalid-conversion flag update |
| inexact_o | output | 1 | Inexact flag update |
| exc_sum_o | output | 1 | Exception-summary update |
| frac_rnd_o | output | 1 | Fraction-rounded status |
| frac_inx_o | output | 1 | Fraction-inexact status |
| ovf_o | output | 1 | Overflow indication |
| sum_ovf_o | output | 1 | Overflow gated by ovf_en_i |

## Verification
Ties and non-ties at 1.5, 2.5 and -2.5 are run in each rounding mode. These cases separate even-rounding from biased rounding and show sign-dependent directed rounding. Tiny magnitudes, subnormals, and operands at and just inside 2^63 and 2^64 show where saturation begins. They also show the one-sided asymmetry of the signed range. NaNs of both kinds, infinities, negative zero and negative unsigned fractions separate invalid from merely inexact results. The same invalid operands are repeated with the trap and overflow-report enables set, so that write suppression and status clearing can be seen apart from the flags.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int FP_EXP_W = 11;
    localparam int FP_MAN_W = 52;
    localparam int DST_W    = 64;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0]         src,
    output logic                         sign,
    output logic                         is_nan,
    output logic                         is_snan,
    output logic                         is_zero,
    output logic                         is_tiny,
    output logic [MAN_W:0]               mant,
    output logic signed [EXP_W+1:0]      e_unb
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [EXP_W+1:0] BIAS_S = BIAS[EXP_W+1:0];

    logic [EXP_W-1:0]        exp_f;
    logic [MAN_W-1:0]        frac_f;
    logic signed [EXP_W+1:0] exp_s;
    logic                    exp_all1;
    logic                    exp_all0;
    logic                    frac_nz;

    assign sign     = src[EXP_W+MAN_W];
    assign exp_f    = src[EXP_W+MAN_W-1:MAN_W];
    assign frac_f   = src[MAN_W-1:0];
    assign exp_all1 = &exp_f;
    assign exp_all0 = ~|exp_f;
    assign frac_nz  = |frac_f;

    assign is_nan  = exp_all1 && frac_nz;
    assign is_snan = is_nan && !frac_f[MAN_W-1];
    assign is_zero = exp_all0 && !frac_nz;
    assign is_tiny = exp_all0 && frac_nz;

    assign mant  = {1'b1, frac_f};
    assign exp_s = {2'b00, exp_f};
    assign e_unb = exp_s - BIAS_S;

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64
) (
    input  logic [MAN_W:0]          mant,
    input  logic signed [EXP_W+1:0] e_unb,
    input  logic                    sign,
    input  logic                    is_zero,
    input  logic                    is_tiny,
    input  rmode_e                  rm,
    output logic                    huge,
    output logic [INT_W:0]          rmag,
    output logic                    round_up,
    output logic                    not_exact
);
    localparam int FX_W = 2 * INT_W;
    localparam int SH_W = $clog2(FX_W);
    localparam logic signed [EXP_W+1:0] LIM_HI = INT_W[EXP_W+1:0];
    localparam logic signed [EXP_W+1:0] LIM_LO = -1;
    localparam int OFF = INT_W - MAN_W;
    localparam logic signed [EXP_W+1:0] OFF_S = OFF[EXP_W+1:0];

    logic signed [EXP_W+1:0] sh_s;
    logic [SH_W-1:0]         shamt;
    logic [FX_W-1:0]         fx;
    logic [INT_W-1:0]        ipart;
    logic                    half;
    logic                    stk;
    logic                    up;

    assign sh_s  = e_unb + OFF_S;
    assign shamt = sh_s[SH_W-1:0];
    assign fx    = {{(FX_W-MAN_W-1){1'b0}}, mant} << shamt;

    always_comb begin
        ipart = '0;
        half  = 1'b0;
        stk   = 1'b0;
        huge  = 1'b0;
        if (is_zero) begin
            stk = 1'b0;
        end else if (e_unb >= LIM_HI) begin
            huge = 1'b1;
        end else if (is_tiny || (e_unb < LIM_LO)) begin
            stk = 1'b1;
        end else begin
            ipart = fx[FX_W-1:INT_W];
            half  = fx[INT_W-1];
            stk   = |fx[INT_W-2:0];
        end
    end

    always_comb begin
        unique case (rm)
            RM_NEAR_EVEN: up = half && (stk || ipart[0]);
            RM_TO_ZERO:   up = 1'b0;
            RM_TO_POS:    up = !sign && (half || stk);
            RM_TO_NEG:    up = sign && (half || stk);
            default:      up = 1'b0;
        endcase
    end

    assign rmag      = {1'b0, ipart} + {{INT_W{1'b0}}, up};
    assign round_up  = up;
    assign not_exact = half || stk;

endmodule

// File: rtl/fcvt_range.sv
module fcvt_range #(
    parameter int INT_W = 64
) (
    input  logic              sign,
    input  logic              is_signed,
    input  logic              is_nan,
    input  logic              huge,
    input  logic [INT_W:0]    rmag,
    output logic [INT_W-1:0]  res,
    output logic              ovf
);
    localparam logic [INT_W:0]   S_POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
    localparam logic [INT_W:0]   S_NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] S_MAX     = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] S_MIN     = {1'b1, {(INT_W-1){1'b0}}};

    always_comb begin
        res = '0;
        ovf = 1'b0;
        if (is_nan) begin
            ovf = 1'b1;
            res = is_signed ? S_MIN : '0;
        end else if (is_signed) begin
            if (!sign) begin
                if (huge || (rmag > S_POS_LIM)) begin
                    ovf = 1'b1;
                    res = S_MAX;
                end else begin
                    res = rmag[INT_W-1:0];
                end
            end else begin
                if (huge || (rmag > S_NEG_LIM)) begin
                    ovf = 1'b1;
                    res = S_MIN;
                end else begin
                    res = -rmag[INT_W-1:0];
                end
            end
        end else begin
            if (!sign) begin
                if (huge || rmag[INT_W]) begin
                    ovf = 1'b1;
                    res = '1;
                end else begin
                    res = rmag[INT_W-1:0];
                end
            end else if (huge || (rmag != '0)) begin
                ovf = 1'b1;
                res = '0;
            end
        end
    end

endmodule

// File: rtl/fcvt_f2i.sv
module fcvt_f2i
    import fcvt_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W,
    parameter int INT_W = DST_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EXP_W+MAN_W:0]   src_i,
    input  logic                   is_signed_i,
    input  logic [1:0]             rmode_i,
    input  logic                   inv_en_i,
    input  logic                   ovf_en_i,
    output logic [INT_W-1:0]       res_o,
    output logic                   wr_en_o,
    output logic                   sig_nan_o,
    output logic                   inv_cvt_o,
    output logic                   inexact_o,
    output logic                   exc_sum_o,
    output logic                   frac_rnd_o,
    output logic                   frac_inx_o,
    output logic                   ovf_o,
    output logic                   sum_ovf_o
);
    logic                    c_sign;
    logic                    c_nan;
    logic                    c_snan;
    logic                    c_zero;
    logic                    c_tiny;
    logic [MAN_W:0]          c_mant;
    logic signed [EXP_W+1:0] c_eunb;

    logic                    r_huge;
    logic [INT_W:0]          r_mag;
    logic                    r_up;
    logic                    r_inx;

    logic [INT_W-1:0]        s_res;
    logic                    s_ovf;

    logic                    n_cvi;
    logic                    n_inx;
    logic                    n_trap;

    fcvt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .src     (src_i),
        .sign    (c_sign),
        .is_nan  (c_nan),
        .is_snan (c_snan),
        .is_zero (c_zero),
        .is_tiny (c_tiny),
        .mant    (c_mant),
        .e_unb   (c_eunb)
    );

    fcvt_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_rnd (
        .mant      (c_mant),
        .e_unb     (c_eunb),
        .sign      (c_sign),
        .is_zero   (c_zero),
        .is_tiny   (c_tiny),
        .rm        (rmode_e'(rmode_i)),
        .huge      (r_huge),
        .rmag      (r_mag),
        .round_up  (r_up),
        .not_exact (r_inx)
    );

    fcvt_range #(.INT_W(INT_W)) u_rng (
        .sign      (c_sign),
        .is_signed (is_signed_i),
        .is_nan    (c_nan),
        .huge      (r_huge),
        .rmag      (r_mag),
        .res       (s_res),
        .ovf       (s_ovf)
    );

    assign n_cvi  = s_ovf;
    assign n_inx  = r_inx && !s_ovf;
    assign n_trap = inv_en_i && (c_snan || n_cvi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o      <= '0;
            wr_en_o    <= 1'b0;
            sig_nan_o  <= 1'b0;
            inv_cvt_o  <= 1'b0;
            inexact_o  <= 1'b0;
            exc_sum_o  <= 1'b0;
            frac_rnd_o <= 1'b0;
            frac_inx_o <= 1'b0;
            ovf_o      <= 1'b0;
            sum_ovf_o  <= 1'b0;
        end else begin
            res_o      <= s_res;
            wr_en_o    <= !n_trap;
            sig_nan_o  <= c_snan;
            inv_cvt_o  <= n_cvi;
            inexact_o  <= n_inx;
            exc_sum_o  <= c_snan || n_cvi || n_inx;
            frac_rnd_o <= !n_trap && r_up;
            frac_inx_o <= !n_trap && n_inx;
            ovf_o      <= s_ovf;
            sum_ovf_o  <= s_ovf && ovf_en_i;
        end
    end

endmodule

// File: rtl/fcvt_f2i_chk.sv
module fcvt_f2i_chk (
    input logic clk,
    input logic rst_n,
    input logic inv_en_i,
    input logic ovf_en_i,
    input logic wr_en_o,
    input logic sig_nan_o,
    input logic inv_cvt_o,
    input logic inexact_o,
    input logic exc_sum_o,
    input logic frac_rnd_o,
    input logic frac_inx_o,
    input logic ovf_o,
    input logic sum_ovf_o
);
    AST_SUM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        sum_ovf_o |-> (ovf_o && $past(ovf_en_i))); // R9
    AST_CVI_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (inv_cvt_o && !inexact_o)); // R3
    AST_TRAP_CLEARS_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> (!frac_rnd_o && !frac_inx_o)); // R8
    AST_TRAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && (inv_cvt_o || sig_nan_o)) |-> $past(inv_en_i)); // R8
    AST_NO_TRAP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !($past(inv_en_i) && (inv_cvt_o || sig_nan_o))); // R8
    AST_EXC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_nan_o || inv_cvt_o || inexact_o) |-> exc_sum_o); // R7
    AST_SNAN_IS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        sig_nan_o |-> (ovf_o && inv_cvt_o)); // R6
endmodule

bind fcvt_f2i fcvt_f2i_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_en_i   (inv_en_i),
    .ovf_en_i   (ovf_en_i),
    .wr_en_o    (wr_en_o),
    .sig_nan_o  (sig_nan_o),
    .inv_cvt_o  (inv_cvt_o),
    .inexact_o  (inexact_o),
    .exc_sum_o  (exc_sum_o),
    .frac_rnd_o (frac_rnd_o),
    .frac_inx_o (frac_inx_o),
    .ovf_o      (ovf_o),
    .sum_ovf_o  (sum_ovf_o)
);

// File: tb/fcvt_f2i_tb.sv
`timescale 1ns/1ps
module fcvt_f2i_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        is_signed_i = 1'b0;
    logic [1:0]  rmode_i = 2'b00;
    logic        inv_en_i = 1'b0;
    logic        ovf_en_i = 1'b0;
    logic [63:0] res_o;
    logic        wr_en_o, sig_nan_o, inv_cvt_o, inexact_o, exc_sum_o;
    logic        frac_rnd_o, frac_inx_o, ovf_o, sum_ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fcvt_f2i u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .is_signed_i(is_signed_i),
        .rmode_i(rmode_i), .inv_en_i(inv_en_i), .ovf_en_i(ovf_en_i),
        .res_o(res_o), .wr_en_o(wr_en_o), .sig_nan_o(sig_nan_o),
        .inv_cvt_o(inv_cvt_o), .inexact_o(inexact_o), .exc_sum_o(exc_sum_o),
        .frac_rnd_o(frac_rnd_o), .frac_inx_o(frac_inx_o), .ovf_o(ovf_o),
        .sum_ovf_o(sum_ovf_o)
    );

    // flag order: wr, snan, cvi, inx, fx, fr, fi, ovf, so
    function automatic logic [8:0] flags();
        return {wr_en_o, sig_nan_o, inv_cvt_o, inexact_o, exc_sum_o,
                frac_rnd_o, frac_inx_o, ovf_o, sum_ovf_o};
    endfunction

    task automatic check(string tag, logic [63:0] exp_res, logic [8:0] exp_fl);
        checks++;
        if (res_o !== exp_res || flags() !== exp_fl) begin
            errors++;
            $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b",
                     tag, res_o, flags(), exp_res, exp_fl);
        end
    endtask

    task automatic apply(string tag, logic [63:0] s, logic sg, logic [1:0] rm,
                         logic ie, logic oe, logic [63:0] exp_res, logic [8:0] exp_fl);
        @(negedge clk);
        src_i = s; is_signed_i = sg; rmode_i = rm; inv_en_i = ie; ovf_en_i = oe;
        @(posedge clk);
        #1;
        check(tag, exp_res, exp_fl);
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset state", 64'h0, 9'b0);
        src_i = 64'h3FF8000000000000;
        @(posedge clk); #1;
        check("R1 held in reset", 64'h0, 9'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_round_modes();
        apply("R2 R10 1.5 nearest", 64'h3FF8000000000000, 1, 2'b00, 0, 0, 64'd2, 9'b100111100);
        apply("R2 2.5 nearest tie even", 64'h4004000000000000, 1, 2'b00, 0, 0, 64'd2, 9'b100110100);
        apply("R2 R10 2.5 to +inf", 64'h4004000000000000, 1, 2'b10, 0, 0, 64'd3, 9'b100111100);
        apply("R2 2.5 to -inf", 64'h4004000000000000, 1, 2'b11, 0, 0, 64'd2, 9'b100110100);
        apply("R2 R10 -2.5 to -inf", 64'hC004000000000000, 1, 2'b11, 0, 0,
              64'hFFFFFFFFFFFFFFFD, 9'b100111100);
        apply("R2 -2.5 to zero", 64'hC004000000000000, 1, 2'b01, 0, 0,
              64'hFFFFFFFFFFFFFFFE, 9'b100110100);
    endtask

    task automatic t_exact();
        apply("R2 R5 exact 42", 64'h4045000000000000, 1, 2'b00, 0, 0, 64'd42, 9'b100000000);
        apply("R5 minus zero", 64'h8000000000000000, 0, 2'b00, 0, 0, 64'd0, 9'b100000000);
        apply("R5 2^64-2048 unsigned", 64'h43EFFFFFFFFFFFFF, 0, 2'b00, 0, 0,
              64'hFFFFFFFFFFFFF800, 9'b100000000);
        apply("R4 -2^63 signed fits", 64'hC3E0000000000000, 1, 2'b00, 0, 0,
              64'h8000000000000000, 9'b100000000);
        apply("R4 2^63 unsigned fits", 64'h43E0000000000000, 0, 2'b00, 0, 0,
              64'h8000000000000000, 9'b100000000);
    endtask

    task automatic t_tiny();
        apply("R5 0.5 nearest", 64'h3FE0000000000000, 1, 2'b00, 0, 0, 64'd0, 9'b100110100);
        apply("R10 0.25 to +inf", 64'h3FD0000000000000, 1, 2'b10, 0, 0, 64'd1, 9'b100111100);
        apply("R10 -subnormal to -inf", 64'h8000000000000001, 1, 2'b11, 0, 0,
              64'hFFFFFFFFFFFFFFFF, 9'b100111100);
        apply("R5 -0.3 unsigned to zero", 64'hBFD3333333333333, 0, 2'b01, 0, 0,
              64'd0, 9'b100110100);
    endtask

    task automatic t_saturate();
        apply("R3 R4 2^63 signed", 64'h43E0000000000000, 1, 2'b00, 0, 0,
              64'h7FFFFFFFFFFFFFFF, 9'b101010010);
        apply("R4 +inf unsigned", 64'h7FF0000000000000, 0, 2'b00, 0, 0,
              64'hFFFFFFFFFFFFFFFF, 9'b101010010);
        apply("R3 R4 -1.0 unsigned", 64'hBFF0000000000000, 0, 2'b00, 0, 0,
              64'd0, 9'b101010010);
        apply("R4 -inf signed", 64'hFFF0000000000000, 1, 2'b01, 0, 0,
              64'h8000000000000000, 9'b101010010);
    endtask

    task automatic t_nan();
        apply("R4 R6 quiet NaN signed", 64'h7FF8000000000000, 1, 2'b00, 0, 0,
              64'h8000000000000000, 9'b101010010);
        apply("R6 R7 signaling NaN unsigned", 64'h7FF0000000000001, 0, 2'b00, 0, 0,
              64'd0, 9'b111010010);
    endtask

    task automatic t_enables();
        apply("R9 2^63 signed report on", 64'h43E0000000000000, 1, 2'b00, 0, 1,
              64'h7FFFFFFFFFFFFFFF, 9'b101010011);
        apply("R8 signaling NaN trapped", 64'h7FF0000000000001, 0, 2'b00, 1, 0,
              64'd0, 9'b011010010);
        apply("R8 R9 overflow trapped", 64'h43E0000000000000, 1, 2'b00, 1, 1,
              64'h7FFFFFFFFFFFFFFF, 9'b001010011);
        apply("R8 trap enable no invalid", 64'h3FF8000000000000, 1, 2'b00, 1, 1,
              64'd2, 9'b100111100);
        apply("R9 report on no overflow", 64'h4045000000000000, 1, 2'b00, 0, 1,
              64'd42, 9'b100000000);
    endtask

    initial begin
        t_reset();
        t_round_modes();
        t_exact();
        t_tiny();
        t_saturate();
        t_nan();
        t_enables();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
        end
        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule